// File: doc/BRIEF.md
# Local Alignment Scoring Cell

This block is one processing element of a systolic dynamic-programming engine that scores local alignment between two DNA sequences. Each cycle it can take three scores from neighbouring cells (the diagonal neighbour, the cell above and the cell to the left) and one 2-bit base from each of the two sequences. From these it forms three candidates. The first is the diagonal score rewarded for a base match or penalised for a mismatch. The other two are the upper and left scores, each reduced by a gap penalty. The cell keeps the largest candidate, never lets it drop below zero, and registers it.

The array's scheduler raises the enable only on the cycle when this cell's anti-diagonal is being computed. On that clock edge the cell registers its new score and both input bases, and passes them on to its right and lower neighbours. When the enable is low the registered outputs stay as they are. The penalties default to +1 for a match, −1 for a mismatch and −2 for a gap. The score width is a parameter, with a default of 6 bits.

Top module: `align_cell`

## Requirements
- R1: An active-high synchronous reset sets `scoreOut`, `baseAOut` and `baseBOut` to zero at the next rising clock edge.
- R2: With `rst` low and `en` low, all three registered outputs keep their values across the clock edge, whatever the data inputs do.
- R3: With `en` high and `baseAIn` equal to `baseBIn`, the diagonal candidate is `diagIn + 1`.
- R4: With `en` high and `baseAIn` different from `baseBIn`, the diagonal candidate is `diagIn - 1`.
- R5: The upper candidate is `upIn - 2` and the left candidate is `leftIn - 2`. With `en` high, the edge loads `scoreOut` with the largest of the three candidates, so the result appears one cycle after the inputs are presented.
- R6: When every candidate is negative, the registered score is 0. A score of 0 or 1 minus the gap penalty never wraps to a large value.
- R7: With `en` high, `baseAOut` and `baseBOut` take `baseAIn` and `baseBIn` at the same edge as the score. The base encoding is A=00, C=01, G=10, T=11.
- R8: A candidate above 2^SCORE_W−1 is stored as 2^SCORE_W−1. An example is a match on a diagonal score that is already at the maximum.
- R9: When `rst` and `en` are high in the same cycle, reset wins and the outputs become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | High on the cycle when this cell's anti-diagonal is computed |
| diagIn | input | SCORE_W | Score of the diagonal (up-left) neighbour |
| upIn | input | SCORE_W | Score of the upper neighbour |
| leftIn | input | SCORE_W | Score of the left neighbour |
| baseAIn | input | 2 | Base of sequence 1 arriving at this cell |
| baseBIn | input | 2 | Base of sequence 2 arriving at this cell |
| scoreOut | output | SCORE_W | Registered cell score |
| baseAOut | output | 2 | Registered sequence-1 base, forwarded to the neighbour |
| baseBOut | output | 2 | Registered sequence-2 base, forwarded to the neighbour |

## Verification
Two functions of this cell can fall in the same cycle: the reset clear and the enabled score load. The bench raises `en` together with `rst` while the data inputs would produce a non-zero score and non-zero bases. It then expects all-zero outputs at the next edge. The score selection has its own same-cycle conflicts: a match and a gap candidate that tie, and a match at the ceiling that meets saturation. Directed cases set these up, and a bench model that computes in signed integers judges every one.

// File: rtl/align_cell_pkg.sv
package align_cell_pkg;

  typedef logic [1:0] base_t;

  typedef enum logic [1:0] {
    BASE_A = 2'b00,
    BASE_C = 2'b01,
    BASE_G = 2'b10,
    BASE_T = 2'b11
  } base_code_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
  } cell_strobe_t;

endpackage

// File: rtl/align_cell_ctrl.sv
module align_cell_ctrl
  import align_cell_pkg::*;
(
  input  logic         rst,
  input  logic         en,
  output cell_strobe_t strobe
);

  // Reset takes priority over an active anti-diagonal slot
  always_comb begin
    strobe.clear = rst;
    strobe.load  = en & ~rst;
  end

endmodule

// File: rtl/align_cell_dp.sv
module align_cell_dp
  import align_cell_pkg::*;
#(
  parameter int SCORE_W       = 6,
  parameter int MATCH_BONUS   = 1,
  parameter int MISMATCH_COST = 1,
  parameter int GAP_COST      = 2
) (
  input  logic               clk,
  input  cell_strobe_t       strobe,
  input  logic [SCORE_W-1:0] diagIn,
  input  logic [SCORE_W-1:0] upIn,
  input  logic [SCORE_W-1:0] leftIn,
  input  base_t              baseAIn,
  input  base_t              baseBIn,
  output logic [SCORE_W-1:0] scoreOut,
  output base_t              baseAOut,
  output base_t              baseBOut
);

  // Sign bit plus carry bit beyond the score width
  localparam int CAND_W   = SCORE_W + 2;
  localparam int N_GAP    = 2;
  localparam int N_CAND   = N_GAP + 1;
  localparam logic signed [CAND_W-1:0] kMatch    = CAND_W'(MATCH_BONUS);
  localparam logic signed [CAND_W-1:0] kMismatch = CAND_W'(MISMATCH_COST);
  localparam logic signed [CAND_W-1:0] kGap      = CAND_W'(GAP_COST);
  localparam logic signed [CAND_W-1:0] kCeil     = CAND_W'((1 << SCORE_W) - 1);

  logic [SCORE_W-1:0]       gapSrc [N_GAP];
  logic signed [CAND_W-1:0] cand   [N_CAND];
  logic signed [CAND_W-1:0] best;
  logic [SCORE_W-1:0]       cellScore;
  logic                     isMatch;

  assign gapSrc[0] = upIn;
  assign gapSrc[1] = leftIn;
  assign isMatch   = (baseAIn == baseBIn);

  // Diagonal candidate: reward or penalty from base comparison
  always_comb begin
    if (isMatch) cand[0] = signed'({2'b00, diagIn}) + kMatch;
    else         cand[0] = signed'({2'b00, diagIn}) - kMismatch;
  end

  // Gap candidates: one per neighbour feeding a gap
  for (genvar g = 0; g < N_GAP; g++) begin : g_gap
    assign cand[g+1] = signed'({2'b00, gapSrc[g]}) - kGap;
  end

  // Maximum over all candidates
  always_comb begin
    best = cand[0];
    for (int k = 1; k < N_CAND; k++) begin
      if (cand[k] > best) best = cand[k];
    end
  end

  // Floor at zero, ceiling at the largest representable score
  always_comb begin
    if (best < 0)          cellScore = '0;
    else if (best > kCeil) cellScore = '1;
    else                   cellScore = best[SCORE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      scoreOut <= '0;
      baseAOut <= '0;
      baseBOut <= '0;
    end else if (strobe.load) begin
      scoreOut <= cellScore;
      baseAOut <= baseAIn;
      baseBOut <= baseBIn;
    end
  end

endmodule

// File: rtl/align_cell.sv
module align_cell
  import align_cell_pkg::*;
#(
  parameter int SCORE_W       = 6,
  parameter int MATCH_BONUS   = 1,
  parameter int MISMATCH_COST = 1,
  parameter int GAP_COST      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [SCORE_W-1:0] diagIn,
  input  logic [SCORE_W-1:0] upIn,
  input  logic [SCORE_W-1:0] leftIn,
  input  logic [1:0]         baseAIn,
  input  logic [1:0]         baseBIn,
  output logic [SCORE_W-1:0] scoreOut,
  output logic [1:0]         baseAOut,
  output logic [1:0]         baseBOut
);

  cell_strobe_t strobe;

  align_cell_ctrl u_ctrl (
    .rst    (rst),
    .en     (en),
    .strobe (strobe)
  );

  align_cell_dp #(
    .SCORE_W       (SCORE_W),
    .MATCH_BONUS   (MATCH_BONUS),
    .MISMATCH_COST (MISMATCH_COST),
    .GAP_COST      (GAP_COST)
  ) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .diagIn   (diagIn),
    .upIn     (upIn),
    .leftIn   (leftIn),
    .baseAIn  (baseAIn),
    .baseBIn  (baseBIn),
    .scoreOut (scoreOut),
    .baseAOut (baseAOut),
    .baseBOut (baseBOut)
  );

endmodule

// File: rtl/align_cell_chk.sv
module align_cell_chk #(
  parameter int SCORE_W  = 6,
  parameter int GAP_COST = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [SCORE_W-1:0] diagIn,
  input logic [SCORE_W-1:0] upIn,
  input logic [SCORE_W-1:0] leftIn,
  input logic [1:0]         baseAIn,
  input logic [1:0]         baseBIn,
  input logic [SCORE_W-1:0] scoreOut,
  input logic [1:0]         baseAOut,
  input logic [1:0]         baseBOut
);

  localparam logic [SCORE_W-1:0] kMax = '1;
  localparam logic [SCORE_W-1:0] kGap = SCORE_W'(GAP_COST);

  // R1 and R9: reset clears everything, enable or not
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (scoreOut == '0 && baseAOut == 2'b00 && baseBOut == 2'b00));

  // R2: idle slot holds state
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(scoreOut) && $stable(baseAOut) && $stable(baseBOut)));

  // R3: a match beats the diagonal score when no ceiling is hit
  p_match_gain_r3: assert property (@(posedge clk) disable iff (rst)
    (en && baseAIn == baseBIn && diagIn != kMax) |=> (scoreOut > $past(diagIn)));

  // R4: a mismatch loses at most one point
  p_mismatch_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (en && baseAIn != baseBIn && diagIn != '0) |=> (scoreOut >= $past(diagIn) - SCORE_W'(1)));

  // R5: gap candidates are lower bounds of the result
  p_gap_up_r5: assert property (@(posedge clk) disable iff (rst)
    (en && upIn >= kGap) |=> (scoreOut >= $past(upIn) - kGap));
  p_gap_left_r5: assert property (@(posedge clk) disable iff (rst)
    (en && leftIn >= kGap) |=> (scoreOut >= $past(leftIn) - kGap));

  // R6: all candidates negative gives zero
  p_zero_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (en && diagIn == '0 && baseAIn != baseBIn && upIn < kGap && leftIn < kGap)
      |=> (scoreOut == '0));

  // R7: bases forwarded with the score
  p_base_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    en |=> (baseAOut == $past(baseAIn) && baseBOut == $past(baseBIn)));

  // R8: saturation at the top of the range
  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (en && baseAIn == baseBIn && diagIn == kMax) |=> (scoreOut == kMax));

endmodule

bind align_cell align_cell_chk #(
  .SCORE_W  (SCORE_W),
  .GAP_COST (GAP_COST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .diagIn   (diagIn),
  .upIn     (upIn),
  .leftIn   (leftIn),
  .baseAIn  (baseAIn),
  .baseBIn  (baseBIn),
  .scoreOut (scoreOut),
  .baseAOut (baseAOut),
  .baseBOut (baseBOut)
);

// File: tb/tb_align_cell.sv
`timescale 1ns/1ps
module tb_align_cell;
  import align_cell_pkg::*;

  localparam int W       = 6;
  localparam int MAXS    = (1 << W) - 1;
  localparam int WDOG_NS = 100000;

  logic         clk = 1'b0;
  logic         rst, en;
  logic [W-1:0] diagIn, upIn, leftIn;
  logic [1:0]   baseAIn, baseBIn;
  logic [W-1:0] scoreOut;
  logic [1:0]   baseAOut, baseBOut;

  int checks = 0;
  int errors = 0;
  int expScore = 0;
  int expA = 0;
  int expB = 0;
  bit done = 0;

  always #4 clk = ~clk;

  align_cell #(.SCORE_W(W)) dut (
    .clk(clk), .rst(rst), .en(en),
    .diagIn(diagIn), .upIn(upIn), .leftIn(leftIn),
    .baseAIn(baseAIn), .baseBIn(baseBIn),
    .scoreOut(scoreOut), .baseAOut(baseAOut), .baseBOut(baseBOut)
  );

  function automatic int cellModel(int d, int u, int l, int a, int b);
    int m;
    m = (a == b) ? d + 1 : d - 1;
    if (u - 2 > m) m = u - 2;
    if (l - 2 > m) m = l - 2;
    if (m < 0) m = 0;
    if (m > MAXS) m = MAXS;
    return m;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, int'(scoreOut), expScore);
    check(tag, int'(baseAOut), expA);
    check(tag, int'(baseBOut), expB);
  endtask

  // Present inputs at the falling edge, update the model, sample after the rising edge
  task automatic step(input bit r, input bit e, input int d, input int u, input int l,
                      input int a, input int b);
    @(negedge clk);
    rst = r; en = e;
    diagIn = W'(d); upIn = W'(u); leftIn = W'(l);
    baseAIn = 2'(a); baseBIn = 2'(b);
    if (r) begin
      expScore = 0; expA = 0; expB = 0;
    end else if (e) begin
      expScore = cellModel(d, u, l, a, b);
      expA = a; expB = b;
    end
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(WDOG_NS);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; en = 1'b0;
    diagIn = '0; upIn = '0; leftIn = '0; baseAIn = '0; baseBIn = '0;

    // R1: reset state
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    checkAll("R1 reset");

    // R3: match on the diagonal
    step(0, 1, 5, 0, 0, BASE_G, BASE_G);
    check("R3 match", int'(scoreOut), 6);
    // R4: mismatch on the diagonal
    step(0, 1, 5, 0, 0, BASE_A, BASE_T);
    check("R4 mismatch", int'(scoreOut), 4);
    // R5: gap from above wins
    step(0, 1, 3, 20, 4, BASE_C, BASE_A);
    check("R5 up gap", int'(scoreOut), 18);
    // R5: gap from left wins
    step(0, 1, 3, 4, 30, BASE_C, BASE_C);
    check("R5 left gap", int'(scoreOut), 28);
    // R5: tie between match and gap
    step(0, 1, 9, 12, 0, BASE_T, BASE_T);
    check("R5 tie", int'(scoreOut), 10);
    // R6: all candidates negative
    step(0, 1, 0, 1, 1, BASE_A, BASE_C);
    check("R6 floor", int'(scoreOut), 0);
    step(0, 1, 0, 0, 0, BASE_G, BASE_T);
    check("R6 floor zero inputs", int'(scoreOut), 0);
    // R8: saturation at the ceiling
    step(0, 1, MAXS, MAXS, MAXS, BASE_A, BASE_A);
    check("R8 saturate", int'(scoreOut), MAXS);
    // R7: each base code forwarded
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 2, 2, 2, k, 3 - k);
      check("R7 baseA", int'(baseAOut), k);
      check("R7 baseB", int'(baseBOut), 3 - k);
    end
    // R2: idle slots ignore changing inputs
    step(0, 1, 40, 0, 0, BASE_C, BASE_C);
    for (int k = 0; k < 6; k++) begin
      step(0, 0, $urandom_range(MAXS), $urandom_range(MAXS), $urandom_range(MAXS),
           $urandom_range(3), $urandom_range(3));
      checkAll("R2 hold");
    end
    check("R2 held score", int'(scoreOut), 41);
    // R9: reset and enable together
    step(1, 1, 30, 30, 30, BASE_T, BASE_T);
    checkAll("R9 reset priority");
    check("R9 score zero", int'(scoreOut), 0);

    // Constrained random traffic against the model
    for (int k = 0; k < 400; k++) begin
      bit e;
      int a, b;
      e = ($urandom_range(3) != 0);
      a = $urandom_range(3);
      b = ($urandom_range(1) != 0) ? a : $urandom_range(3);
      if ($urandom_range(7) == 0)
        step(0, e, $urandom_range(2), $urandom_range(2), $urandom_range(2), a, b);
      else
        step(0, e, $urandom_range(MAXS), $urandom_range(MAXS), $urandom_range(MAXS), a, b);
      checkAll(e ? "R5 random" : "R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule